// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block holds the programmer-visible data registers of a 16-bit processor core: eight 16-bit general registers and four 16-bit segment registers. The lower four general registers can also be reached as independent 8-bit halves. Byte operations can therefore work alongside word operations on the same storage.

Two read ports and one write port serve the general registers. Each port carries a 3-bit register index and a byte/word mode bit. A separate port reads and writes the segment registers. The code-segment register cannot be written through that port. It changes only through a dedicated far-transfer load strobe, which the core raises for far jumps, far calls and far returns. Reads are combinational, and every write lands on the next rising clock edge.

Top module: `gpr_file_top`

## Requirements
- R1: In word mode, index values 0 to 7 select the sixteen-bit registers in the order AX, CX, DX, BX, SP, BP, SI, DI, on both read ports and on the write port.
- R2: In byte mode, index values 0 to 3 select the low halves AL, CL, DL, BL and values 4 to 7 select the high halves AH, CH, DH, BH. The low half is bits 7:0 of the word and the high half is bits 15:8.
- R3: A byte write stores wrData[7:0] into the selected half and leaves the other half of the same register unchanged.
- R4: Both read ports are combinational and independent. A write with wrEn high becomes visible only after the next rising clock edge.
- R5: A byte-mode read returns the selected half in bits 7:0, with bits 15:8 at zero.
- R6: The segment port uses index 0 = ES, 1 = CS, 2 = SS, 3 = DS. segWrEn writes ES, SS or DS on the next edge. A segment-port write addressed to CS leaves CS unchanged.
- R7: A cycle with farLoadEn high loads farCsData into CS on the next edge. CS changes by no other path.
- R8: An active-low reset clears all twelve registers to zero.
- R9: With wrEn and segWrEn low, no general or segment register changes, whatever the data and index inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdIdxA | input | 3 | Read port A register index |
| rdByteA | input | 1 | Read port A byte mode |
| rdDataA | output | 16 | Read port A data |
| rdIdxB | input | 3 | Read port B register index |
| rdByteB | input | 1 | Read port B byte mode |
| rdDataB | output | 16 | Read port B data |
| wrEn | input | 1 | General write enable |
| wrIdx | input | 3 | General write index |
| wrByte | input | 1 | General write byte mode |
| wrData | input | 16 | General write data |
| segRdIdx | input | 2 | Segment read index |
| segRdData | output | 16 | Segment read data |
| segWrEn | input | 1 | Segment write enable |
| segWrIdx | input | 2 | Segment write index |
| segWrData | input | 16 | Segment write data |
| farLoadEn | input | 1 | Far-transfer CS load strobe |
| farCsData | input | 16 | New CS value for the far load |

## Verification
The bench builds the block with the package defaults: eight general registers, four segment registers and 16-bit words. With these values every word index, every byte index and every segment index can be reached directly. The bench covers each alias pairing, such as BL against BX and AH against AX, and every byte lane in both directions. It also covers each segment slot, including a blocked write to CS followed by a far load into it.

// File: rtl/gpr_file_pkg.sv
package gpr_file_pkg;
  parameter int WORD_W    = 16;
  parameter int BYTE_W    = WORD_W / 2;
  parameter int GPR_COUNT = 8;
  parameter int SEG_COUNT = 4;
  parameter int GIDX_W    = $clog2(GPR_COUNT);
  parameter int SIDX_W    = $clog2(SEG_COUNT);
  parameter int SPLIT_CNT = GPR_COUNT / 2;
  parameter int CS_IDX    = 1;

  typedef struct packed {
    logic [GPR_COUNT-1:0] loEn;
    logic [GPR_COUNT-1:0] hiEn;
    logic                 hiFromLow;
    logic [SEG_COUNT-1:0] segEn;
  } rfStrobe_t;
endpackage

// File: rtl/gpr_file_ctrl.sv
module gpr_file_ctrl
  import gpr_file_pkg::*;
(
  input  logic              wrEn,
  input  logic [GIDX_W-1:0] wrIdx,
  input  logic              wrByte,
  input  logic              segWrEn,
  input  logic [SIDX_W-1:0] segWrIdx,
  input  logic              farLoadEn,
  output rfStrobe_t         strobes
);
  localparam int HALF_W = GIDX_W - 1;

  logic [GIDX_W-1:0] byteTarget;
  logic              byteHigh;

  always_comb begin
    byteTarget = {1'b0, wrIdx[HALF_W-1:0]};
    byteHigh   = wrIdx[GIDX_W-1];
  end

  always_comb begin
    strobes.hiFromLow = wrByte;
    for (int i = 0; i < GPR_COUNT; i++) begin
      if (wrByte) begin
        strobes.loEn[i] = wrEn && !byteHigh && (byteTarget == GIDX_W'(i));
        strobes.hiEn[i] = wrEn &&  byteHigh && (byteTarget == GIDX_W'(i));
      end else begin
        strobes.loEn[i] = wrEn && (wrIdx == GIDX_W'(i));
        strobes.hiEn[i] = wrEn && (wrIdx == GIDX_W'(i));
      end
    end
    for (int j = 0; j < SEG_COUNT; j++) begin
      if (j == CS_IDX) strobes.segEn[j] = farLoadEn;
      else             strobes.segEn[j] = segWrEn && (segWrIdx == SIDX_W'(j));
    end
  end
endmodule

// File: rtl/gpr_file_dp.sv
module gpr_file_dp
  import gpr_file_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] segWrData,
  input  logic [WORD_W-1:0] farCsData,
  input  logic [GIDX_W-1:0] rdIdxA,
  input  logic              rdByteA,
  input  logic [GIDX_W-1:0] rdIdxB,
  input  logic              rdByteB,
  input  logic [SIDX_W-1:0] segRdIdx,
  output logic [WORD_W-1:0] rdDataA,
  output logic [WORD_W-1:0] rdDataB,
  output logic [WORD_W-1:0] segRdData,
  output logic [WORD_W-1:0] csValue
);
  localparam int HALF_W = GIDX_W - 1;

  logic [WORD_W-1:0] gprQ [GPR_COUNT];
  logic [WORD_W-1:0] segQ [SEG_COUNT];
  logic [BYTE_W-1:0] hiSrc;

  assign hiSrc = strobes.hiFromLow ? wrData[BYTE_W-1:0] : wrData[WORD_W-1:BYTE_W];

  for (genvar g = 0; g < GPR_COUNT; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (!rstN) begin
        gprQ[g] <= '0;
      end else begin
        if (strobes.loEn[g]) gprQ[g][BYTE_W-1:0]      <= wrData[BYTE_W-1:0];
        if (strobes.hiEn[g]) gprQ[g][WORD_W-1:BYTE_W] <= hiSrc;
      end
    end
  end

  for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
    if (s == CS_IDX) begin : g_cs
      always_ff @(posedge clk) begin
        if (!rstN)                segQ[s] <= '0;
        else if (strobes.segEn[s]) segQ[s] <= farCsData;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rstN)                segQ[s] <= '0;
        else if (strobes.segEn[s]) segQ[s] <= segWrData;
      end
    end
  end

  function automatic logic [WORD_W-1:0] pickReg(input logic [GIDX_W-1:0] idx,
                                                 input logic byteMode);
    logic [WORD_W-1:0] src;
    if (byteMode) begin
      src = gprQ[{1'b0, idx[HALF_W-1:0]}];
      if (idx[GIDX_W-1]) return {{BYTE_W{1'b0}}, src[WORD_W-1:BYTE_W]};
      else               return {{BYTE_W{1'b0}}, src[BYTE_W-1:0]};
    end
    return gprQ[idx];
  endfunction

  always_comb begin
    rdDataA   = pickReg(rdIdxA, rdByteA);
    rdDataB   = pickReg(rdIdxB, rdByteB);
    segRdData = segQ[segRdIdx];
    csValue   = segQ[CS_IDX];
  end
endmodule

// File: rtl/gpr_file_top.sv
module gpr_file_top
  import gpr_file_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [GIDX_W-1:0] rdIdxA,
  input  logic              rdByteA,
  output logic [WORD_W-1:0] rdDataA,
  input  logic [GIDX_W-1:0] rdIdxB,
  input  logic              rdByteB,
  output logic [WORD_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [GIDX_W-1:0] wrIdx,
  input  logic              wrByte,
  input  logic [WORD_W-1:0] wrData,
  input  logic [SIDX_W-1:0] segRdIdx,
  output logic [WORD_W-1:0] segRdData,
  input  logic              segWrEn,
  input  logic [SIDX_W-1:0] segWrIdx,
  input  logic [WORD_W-1:0] segWrData,
  input  logic              farLoadEn,
  input  logic [WORD_W-1:0] farCsData
);
  rfStrobe_t         strobes;
  logic [WORD_W-1:0] csValue;

  gpr_file_ctrl u_ctrl (
    .wrEn(wrEn), .wrIdx(wrIdx), .wrByte(wrByte),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .farLoadEn(farLoadEn),
    .strobes(strobes)
  );

  gpr_file_dp u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrData(wrData), .segWrData(segWrData), .farCsData(farCsData),
    .rdIdxA(rdIdxA), .rdByteA(rdByteA), .rdIdxB(rdIdxB), .rdByteB(rdByteB),
    .segRdIdx(segRdIdx),
    .rdDataA(rdDataA), .rdDataB(rdDataB), .segRdData(segRdData),
    .csValue(csValue)
  );
endmodule

// File: rtl/gpr_file_chk.sv
module gpr_file_chk
  import gpr_file_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [GIDX_W-1:0] rdIdxA,
  input logic              rdByteA,
  input logic [WORD_W-1:0] rdDataA,
  input logic              rdByteB,
  input logic [WORD_W-1:0] rdDataB,
  input logic              wrEn,
  input logic [GIDX_W-1:0] wrIdx,
  input logic              wrByte,
  input logic [WORD_W-1:0] wrData,
  input logic              farLoadEn,
  input logic [WORD_W-1:0] farCsData,
  input logic [WORD_W-1:0] csValue
);
  // R5: the upper byte of a byte-mode read is always zero
  assert_zext_a_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdByteA |-> (rdDataA[WORD_W-1:BYTE_W] == '0));
  assert_zext_b_R5: assert property (@(posedge clk) disable iff (!rstN)
    rdByteB |-> (rdDataB[WORD_W-1:BYTE_W] == '0));

  // R6 / R7: CS holds its value unless a far load is strobed
  assert_cs_guard_R6: assert property (@(posedge clk) disable iff (!rstN)
    !farLoadEn |=> $stable(csValue));

  // R7: a far load lands on the next edge
  assert_far_load_R7: assert property (@(posedge clk) disable iff (!rstN)
    farLoadEn |=> (csValue == $past(farCsData)));

  // R4: a word write is readable on port A in the following cycle
  assert_word_wr_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrByte) |=>
      (!(rdIdxA == $past(wrIdx) && !rdByteA) || (rdDataA == $past(wrData))));

  // R8: reset clears CS
  assert_reset_cs_R8: assert property (@(posedge clk)
    !rstN |=> (csValue == '0));
endmodule

bind gpr_file_top gpr_file_chk u_chk (
  .clk(clk), .rstN(rstN), .rdIdxA(rdIdxA), .rdByteA(rdByteA), .rdDataA(rdDataA),
  .rdByteB(rdByteB), .rdDataB(rdDataB), .wrEn(wrEn), .wrIdx(wrIdx),
  .wrByte(wrByte), .wrData(wrData), .farLoadEn(farLoadEn),
  .farCsData(farCsData), .csValue(csValue)
);

// File: tb/sim_gpr_file_top.sv
module sim_gpr_file_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  rdIdxA = '0, rdIdxB = '0, wrIdx = '0;
  logic        rdByteA = 1'b0, rdByteB = 1'b0, wrEn = 1'b0, wrByte = 1'b0;
  logic [15:0] wrData = '0, segWrData = '0, farCsData = '0;
  logic [1:0]  segRdIdx = '0, segWrIdx = '0;
  logic        segWrEn = 1'b0, farLoadEn = 1'b0;
  logic [15:0] rdDataA, rdDataB, segRdData;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpr_file_top u0 (
    .clk(clk), .rstN(rstN),
    .rdIdxA(rdIdxA), .rdByteA(rdByteA), .rdDataA(rdDataA),
    .rdIdxB(rdIdxB), .rdByteB(rdByteB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrByte(wrByte), .wrData(wrData),
    .segRdIdx(segRdIdx), .segRdData(segRdData),
    .segWrEn(segWrEn), .segWrIdx(segWrIdx), .segWrData(segWrData),
    .farLoadEn(farLoadEn), .farCsData(farCsData)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic readA(input logic [2:0] idx, input logic byteMode, output logic [15:0] val);
    rdIdxA = idx; rdByteA = byteMode; #1; val = rdDataA;
  endtask

  task automatic readSeg(input logic [1:0] idx, output logic [15:0] val);
    segRdIdx = idx; #1; val = segRdData;
  endtask

  task automatic gprWrite(input logic [2:0] idx, input logic byteMode, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx; wrByte = byteMode; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrByte = 1'b0;
  endtask

  task automatic testReset;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      readA(3'(i), 1'b0, v); check("R8 gpr reset", v, 16'h0);
    end
    for (int j = 0; j < 4; j++) begin
      readSeg(2'(j), v); check("R8 seg reset", v, 16'h0);
    end
  endtask

  task automatic testWordAccess;
    logic [15:0] v;
    // R4: value invisible before the edge
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 3'd0; wrByte = 1'b0; wrData = 16'h1234;
    readA(3'd0, 1'b0, v); check("R4 before edge", v, 16'h0);
    @(negedge clk);
    wrEn = 1'b0;
    readA(3'd0, 1'b0, v); check("R4 after edge", v, 16'h1234);
    for (int i = 1; i < 8; i++) gprWrite(3'(i), 1'b0, 16'h1100 * 16'(i) + 16'(i));
    for (int i = 1; i < 8; i++) begin
      rdIdxB = 3'(i); rdByteB = 1'b0; #1;
      check("R1 word read port B", rdDataB, 16'h1100 * 16'(i) + 16'(i));
    end
    // R4: the two ports read different registers at once
    rdIdxA = 3'd3; rdByteA = 1'b0; rdIdxB = 3'd6; rdByteB = 1'b0; #1;
    check("R4 dual read A (BX)", rdDataA, 16'h3303);
    check("R4 dual read B (SI)", rdDataB, 16'h6606);
  endtask

  task automatic testByteAlias;
    logic [15:0] v;
    readA(3'd0, 1'b1, v); check("R2 AL read", v, 16'h0034);
    readA(3'd4, 1'b1, v); check("R5 AH read zero-extended", v, 16'h0012);
    gprWrite(3'd3, 1'b1, 16'hABCD);   // BL
    readA(3'd3, 1'b0, v); check("R3 BL write keeps BH", v, 16'h33CD);
    gprWrite(3'd7, 1'b1, 16'h00EF);   // BH
    readA(3'd3, 1'b0, v); check("R3 BH write keeps BL", v, 16'hEFCD);
    gprWrite(3'd5, 1'b1, 16'hFF5A);   // CH
    readA(3'd1, 1'b0, v); check("R2 CH maps to CX high", v, 16'h5A01);
    rdIdxB = 3'd2; rdByteB = 1'b1; #1;
    check("R2 DL on port B", rdDataB, 16'h0002);
    readA(3'd7, 1'b0, v); check("R1 DI untouched by BH", v, 16'h7707);
  endtask

  task automatic testSegments;
    logic [15:0] v;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      segWrEn = 1'b1; segWrIdx = 2'(j); segWrData = 16'hA000 + 16'(j);
    end
    @(negedge clk);
    segWrEn = 1'b0;
    readSeg(2'd0, v); check("R6 ES write", v, 16'hA000);
    readSeg(2'd1, v); check("R6 CS write blocked", v, 16'h0000);
    readSeg(2'd2, v); check("R6 SS write", v, 16'hA002);
    readSeg(2'd3, v); check("R6 DS write", v, 16'hA003);
  endtask

  task automatic testFarLoad;
    logic [15:0] v;
    @(negedge clk);
    farLoadEn = 1'b1; farCsData = 16'h6020;
    readSeg(2'd1, v); check("R7 CS before edge", v, 16'h0000);
    @(negedge clk);
    farLoadEn = 1'b0;
    readSeg(2'd1, v); check("R7 CS far load", v, 16'h6020);
    readSeg(2'd3, v); check("R7 DS unaffected", v, 16'hA003);
  endtask

  task automatic testIdle;
    logic [15:0] v;
    @(negedge clk);
    wrIdx = 3'd0; wrByte = 1'b0; wrData = 16'hDEAD;
    segWrIdx = 2'd0; segWrData = 16'hBEEF;
    farCsData = 16'h1111;
    @(negedge clk);
    @(negedge clk);
    readA(3'd0, 1'b0, v); check("R9 AX idle", v, 16'h1234);
    readSeg(2'd0, v); check("R9 ES idle", v, 16'hA000);
    readSeg(2'd1, v); check("R9 CS idle", v, 16'h6020);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testWordAccess();
    testByteAlias();
    testSegments();
    testFarLoad();
    testIdle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule